// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a single-data-rate SDRAM bus and samples them on every rising clock edge. It turns each pin pattern into a decoded command code and keeps, for each of four banks, an open/idle flag and the row that was last activated there. Commands that do not fit the current state of the target bank, or of the device as a whole, raise a one-cycle error pulse. The block is meant to sit beside a memory controller or in a bus monitor, where it reports protocol misuse as it happens.

The tracker also follows the power-state side of the protocol. A refresh pattern counts as auto refresh when the clock enable is high and as self-refresh entry when it is low. During self refresh the bus is ignored until the clock enable comes back. A load of the mode register stores its op-code. The data-mask pin drives two outputs. The write mask follows the pin in the same cycle, and the read mask is a copy of the pin delayed by two clock cycles.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n is high (inhibit), or when cs_n is low and ras_n, cas_n and we_n are all high (no operation), cmd_valid stays low, cmd_code reads 0 and no bank state changes.
- R2: The pin pattern {cs_n,ras_n,cas_n,we_n} is sampled at a clock edge and shows on cmd_valid/cmd_code after that same edge. The codes are: 0011 activate=1, 0101 read=2, 0100 write=3, 0110 burst stop=4, 0010 precharge=5, 0001 with cke high auto refresh=6, 0001 with cke low self refresh=7, 0000 mode load=8.
- R3: An activate to an idle bank (selected by ba) opens it and stores addr[ROW_W-1:0] as its row. The row shows on bank_row[ba*ROW_W +: ROW_W].
- R4: A read or write to an open bank with addr[10] high arms auto precharge. The bank reads as idle from the BURST_LEN-th edge after the command (BURST_LEN=4 by default). With addr[10] low the bank stays open.
- R5: A burst stop closes any bank whose auto precharge is still pending, at the burst stop's own edge.
- R6: cmd_err pulses together with cmd_valid for a read or write to an idle bank and for an activate to an open bank. The rejected activate leaves the stored row unchanged.
- R7: cmd_err pulses for an auto refresh, a self refresh entry or a mode load issued while any bank is open.
- R8: A precharge with addr[10] low closes only bank ba. With addr[10] high it closes all banks whatever ba holds.
- R9: Every mode load stores addr[11:0] on mode_op. With a 13-bit row, addr[12] high during a mode load also raises cmd_err.
- R10: The refresh pattern decodes to auto refresh (code 6) when cke is high and to self refresh entry (code 7) when cke is low.
- R11: Self refresh entry sets self_ref and idles every bank. While self_ref is high, commands give no strobe and change no state. The first edge that samples cke high clears self_ref, ignores the command on the bus and leaves all banks idle.
- R12: wr_mask equals dqm in the same cycle. rd_mask equals dqm as sampled two edges earlier.
- R13: A synchronous active-low reset idles all banks, clears mode_op, self_ref, cmd_valid and cmd_err, and holds wr_mask and rd_mask low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ROW_W | Address pins (row, column with bit 10 flag, op-code) |
| dqm | input | 1 | Data mask pin |
| cmd_valid | output | 1 | A live command was sampled at the last edge |
| cmd_code | output | 4 | Decoded command code |
| cmd_err | output | 1 | Illegal command pulse |
| bank_open | output | NUM_BANKS | Open flag per bank |
| bank_row | output | NUM_BANKS*ROW_W | Stored row per bank |
| mode_op | output | 12 | Last mode-register op-code |
| self_ref | output | 1 | Device is in self refresh |
| wr_mask | output | 1 | Write-data mask, no delay |
| rd_mask | output | 1 | Read-output mask, two-cycle delay |

## Verification
The properties assume that after reset every command pin, bank bit and address bit carries a known level at each sampling edge, and that one command occupies one cycle. The precharge-all and activate checks compare against the previous cycle's addr[10] and ba, so they rely on those pins being valid on command cycles. The stimulus changes pins only on falling edges, never leaves a pin undriven, and holds the data mask low on the cycle that follows reset release. This keeps the two-cycle mask property free of any pre-reset value.

// File: rtl/sdram_trk_pkg.sv
`timescale 1ns/1ps
package sdram_trk_pkg;
   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_BST  = 4'd4,
      CMD_PRE  = 4'd5,
      CMD_AREF = 4'd6,
      CMD_SREF = 4'd7,
      CMD_LMR  = 4'd8
   } trk_cmd_e;

   localparam int AP_BIT = 10;
   localparam int OP_W   = 12;
endpackage

// File: rtl/sdram_trk_decode.sv
`timescale 1ns/1ps
module sdram_trk_decode
   import sdram_trk_pkg::*;
(
   input  logic     cke,
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output trk_cmd_e cmd
);
   always_comb begin
      case ({cs_n, ras_n, cas_n, we_n})
         4'b0011: cmd = CMD_ACT;
         4'b0101: cmd = CMD_RD;
         4'b0100: cmd = CMD_WR;
         4'b0110: cmd = CMD_BST;
         4'b0010: cmd = CMD_PRE;
         4'b0001: cmd = cke ? CMD_AREF : CMD_SREF;
         4'b0000: cmd = CMD_LMR;
         default: cmd = CMD_NOP;
      endcase
   end
endmodule

// File: rtl/sdram_trk_bank.sv
`timescale 1ns/1ps
module sdram_trk_bank #(
   parameter int ROW_W     = 13,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_all,
   input  logic             act_hit,
   input  logic             close_req,
   input  logic             ap_start,
   input  logic             ap_cancel,
   input  logic             bst,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] ap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
         ap_cnt <= '0;
      end else if (clear_all) begin
         open_o <= 1'b0;
         ap_cnt <= '0;
      end else if (act_hit) begin
         open_o <= 1'b1;
         row_o  <= row_in;
         ap_cnt <= '0;
      end else if (close_req) begin
         open_o <= 1'b0;
         ap_cnt <= '0;
      end else if (ap_start) begin
         ap_cnt <= CNT_LOAD;
      end else if (ap_cancel) begin
         ap_cnt <= '0;
      end else if (ap_cnt != '0) begin
         if (bst || ap_cnt == CNT_ONE) begin
            open_o <= 1'b0;
            ap_cnt <= '0;
         end else begin
            ap_cnt <= ap_cnt - CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/sdram_trk_mask.sv
`timescale 1ns/1ps
module sdram_trk_mask #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dqm,
   output logic wr_mask,
   output logic rd_mask
);
   assign wr_mask = dqm & rst_n;

   generate
      if (LAT == 0) begin : g_direct
         assign rd_mask = dqm & rst_n;
      end else begin : g_pipe
         logic [LAT-1:0] stage;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage <= '0;
            end else begin
               stage[0] <= dqm;
               for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
            end
         end
         assign rd_mask = stage[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int ROW_W     = 13,
   parameter int BANK_W    = 2,
   parameter int BURST_LEN = 4,
   localparam int NUM_BANKS = 1 << BANK_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BANK_W-1:0]          ba,
   input  logic [ROW_W-1:0]           addr,
   input  logic                       dqm,
   output logic                       cmd_valid,
   output logic [3:0]                 cmd_code,
   output logic                       cmd_err,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic [OP_W-1:0]            mode_op,
   output logic                       self_ref,
   output logic                       wr_mask,
   output logic                       rd_mask
);
   localparam int RD_MASK_LAT = 2;

   if (ROW_W != 12 && ROW_W != 13) begin : g_bad_row
      $error("sdram_cmd_tracker: ROW_W must be 12 or 13");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("sdram_cmd_tracker: BURST_LEN must be at least 1");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("sdram_cmd_tracker: BANK_W must be at least 1");
   end

   trk_cmd_e cmd;
   logic     live, cmd_on, sr_exit, sr_enter, clear_all;
   logic     any_open, tgt_open, a12_hi, err_d;
   logic     is_rw;

   sdram_trk_decode i_decode (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   generate
      if (ROW_W > OP_W) begin : g_a12
         assign a12_hi = addr[OP_W];
      end else begin : g_no_a12
         assign a12_hi = 1'b0;
      end
   endgenerate

   assign live      = !self_ref;
   assign cmd_on    = live && (cmd != CMD_NOP);
   assign sr_exit   = self_ref && cke;
   assign sr_enter  = live && (cmd == CMD_SREF);
   assign clear_all = sr_exit || sr_enter;
   assign any_open  = |bank_open;
   assign tgt_open  = bank_open[ba];
   assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);

   always_comb begin
      case (cmd)
         CMD_ACT:            err_d = tgt_open;
         CMD_RD, CMD_WR:     err_d = !tgt_open;
         CMD_AREF, CMD_SREF: err_d = any_open;
         CMD_LMR:            err_d = any_open || a12_hi;
         default:            err_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NOP;
         cmd_err   <= 1'b0;
         mode_op   <= '0;
         self_ref  <= 1'b0;
      end else begin
         cmd_valid <= cmd_on;
         cmd_code  <= cmd_on ? cmd : CMD_NOP;
         cmd_err   <= cmd_on && err_d;
         if (cmd_on && cmd == CMD_LMR) mode_op <= addr[OP_W-1:0];
         if (sr_exit)       self_ref <= 1'b0;
         else if (sr_enter) self_ref <= 1'b1;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (ba == BANK_W'(b));

      sdram_trk_bank #(
         .ROW_W     (ROW_W),
         .BURST_LEN (BURST_LEN)
      ) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear_all (clear_all),
         .act_hit   (live && cmd == CMD_ACT && sel && !bank_open[b]),
         .close_req (live && cmd == CMD_PRE && (addr[AP_BIT] || sel)),
         .ap_start  (live && is_rw && sel && bank_open[b] && addr[AP_BIT]),
         .ap_cancel (live && is_rw && sel && !addr[AP_BIT]),
         .bst       (live && cmd == CMD_BST),
         .row_in    (addr),
         .open_o    (bank_open[b]),
         .row_o     (bank_row[b*ROW_W +: ROW_W])
      );
   end

   sdram_trk_mask #(.LAT(RD_MASK_LAT)) i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .dqm     (dqm),
      .wr_mask (wr_mask),
      .rd_mask (rd_mask)
   );
endmodule

// File: rtl/sdram_trk_chk.sv
`timescale 1ns/1ps
module sdram_trk_chk #(
   parameter int BANK_W    = 2,
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dqm,
   input logic                 a10,
   input logic [BANK_W-1:0]    ba,
   input logic                 cmd_valid,
   input logic [3:0]           cmd_code,
   input logic                 cmd_err,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic                 self_ref,
   input logic                 rd_mask
);
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R6
   err_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> cmd_valid);

   // R11
   sref_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref |-> (bank_open == '0));

   // R8
   pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'd5 && $past(a10)) |-> (bank_open == '0));

   // R3
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'd1 && !cmd_err) |-> bank_open[$past(ba)]);

   // R12
   rd_mask_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (rd_mask == $past(dqm, 2)));

   // R11
   sref_entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $rose(self_ref)) |-> (cmd_valid && cmd_code == 4'd7));
endmodule

bind sdram_cmd_tracker sdram_trk_chk #(
   .BANK_W    (BANK_W),
   .NUM_BANKS (NUM_BANKS)
) i_trk_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dqm       (dqm),
   .a10       (addr[10]),
   .ba        (ba),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .cmd_err   (cmd_err),
   .bank_open (bank_open),
   .self_ref  (self_ref),
   .rd_mask   (rd_mask)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
   localparam int ROW_W = 13;
   localparam int NB    = 4;

   localparam logic [3:0] P_INH = 4'b1000, P_NOP = 4'b0111, P_ACT = 4'b0011,
                          P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110,
                          P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic [ROW_W-1:0] addr = '0;
   logic dqm = 1'b0;
   logic cmd_valid, cmd_err, self_ref, wr_mask, rd_mask;
   logic [3:0] cmd_code;
   logic [NB-1:0] bank_open;
   logic [NB*ROW_W-1:0] bank_row;
   logic [11:0] mode_op;

   sdram_cmd_tracker #(.ROW_W(ROW_W), .BANK_W(2), .BURST_LEN(4)) i_sdram_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_err(cmd_err),
      .bank_open(bank_open), .bank_row(bank_row), .mode_op(mode_op),
      .self_ref(self_ref), .wr_mask(wr_mask), .rd_mask(rd_mask)
   );

   always #5 clk = ~clk;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 1'b0;
   bit prev_dqm = 1'b0;

   typedef struct {
      int         due;
      bit         v;
      logic [3:0] code;
      bit         err;
      logic [3:0] open;
      bit         rdm;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: compares outputs after the edge that sampled the command
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         chk({cmd_valid, cmd_code, cmd_err, bank_open, rd_mask} ==
             {e.v, e.code, e.err, e.open, e.rdm}, e.tag,
             "{valid,code,err,open,rd_mask}",
             {cmd_valid, cmd_code, cmd_err, bank_open, rd_mask},
             {e.v, e.code, e.err, e.open, e.rdm});
      end
   end

   // driver: puts one command on the pins and queues its expected result
   task automatic issue(input bit cke_i, input logic [3:0] pins, input logic [1:0] ba_i,
                        input logic [ROW_W-1:0] a_i, input bit dqm_i,
                        input bit ev, input logic [3:0] ecode, input bit eerr,
                        input logic [3:0] eopen, input string tag);
      exp_t e;
      @(negedge clk);
      cke = cke_i;
      {cs_n, ras_n, cas_n, we_n} = pins;
      ba = ba_i; addr = a_i; dqm = dqm_i;
      e.due = cyc + 1; e.v = ev; e.code = ecode; e.err = eerr;
      e.open = eopen; e.rdm = prev_dqm; e.tag = tag;
      sb.push_back(e);
      prev_dqm = dqm_i;
      #1;
      chk(wr_mask == dqm_i, "R12", "wr_mask", wr_mask, dqm_i);
   endtask

   initial begin
      #(2000 * 10);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      dqm = 1'b1;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(bank_open == 0 && cmd_valid == 0 && cmd_err == 0 && self_ref == 0,
          "R13", "status", {bank_open, cmd_valid, cmd_err, self_ref}, 0);
      chk(mode_op == 0, "R13", "mode_op", mode_op, 0);
      chk(wr_mask == 0 && rd_mask == 0, "R13", "masks", {wr_mask, rd_mask}, 0);
      dqm = 1'b0;
      rst_n = 1'b1;

      issue(1, 4'b1001, 2'd1, 13'h0011, 0, 0, 4'd0, 0, 4'b0000, "R1");
      issue(1, P_NOP,   2'd1, 13'h0011, 0, 0, 4'd0, 0, 4'b0000, "R1");
      issue(1, P_ACT,   2'd1, 13'h0155, 0, 1, 4'd1, 0, 4'b0010, "R3");
      issue(1, P_ACT,   2'd1, 13'h00AA, 0, 1, 4'd1, 1, 4'b0010, "R6");
      chk(bank_row[ROW_W +: ROW_W] == 13'h0155, "R3", "row1",
          bank_row[ROW_W +: ROW_W], 13'h0155);
      issue(1, P_RD,    2'd2, 13'h0005, 1, 1, 4'd2, 1, 4'b0010, "R6");
      chk(bank_row[ROW_W +: ROW_W] == 13'h0155, "R6", "row1 kept",
          bank_row[ROW_W +: ROW_W], 13'h0155);
      issue(1, P_WR,    2'd1, 13'h0007, 1, 1, 4'd3, 0, 4'b0010, "R2");
      issue(1, P_ACT,   2'd3, 13'h1ABC, 0, 1, 4'd1, 0, 4'b1010, "R12");
      issue(1, P_RD,    2'd3, 13'h0403, 0, 1, 4'd2, 0, 4'b1010, "R4");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b1010, "R4");
      chk(bank_row[3*ROW_W +: ROW_W] == 13'h1ABC, "R3", "row3",
          bank_row[3*ROW_W +: ROW_W], 13'h1ABC);
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b1010, "R4");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b1010, "R4");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0010, "R4");
      issue(1, P_ACT,   2'd0, 13'h0010, 0, 1, 4'd1, 0, 4'b0011, "R3");
      issue(1, P_WR,    2'd0, 13'h0402, 0, 1, 4'd3, 0, 4'b0011, "R4");
      issue(1, P_BST,   2'd0, 13'h0000, 0, 1, 4'd4, 0, 4'b0010, "R5");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0010, "R5");
      issue(1, P_LMR,   2'd0, 13'h0022, 0, 1, 4'd8, 1, 4'b0010, "R7");
      issue(1, P_REF,   2'd0, 13'h0000, 0, 1, 4'd6, 1, 4'b0010, "R7");
      issue(1, P_ACT,   2'd2, 13'h0005, 0, 1, 4'd1, 0, 4'b0110, "R3");
      issue(1, P_PRE,   2'd1, 13'h0000, 0, 1, 4'd5, 0, 4'b0100, "R8");
      issue(1, P_ACT,   2'd0, 13'h0009, 0, 1, 4'd1, 0, 4'b0101, "R3");
      issue(1, P_PRE,   2'd1, 13'h0400, 0, 1, 4'd5, 0, 4'b0000, "R8");
      issue(1, P_LMR,   2'd0, 13'h0233, 0, 1, 4'd8, 0, 4'b0000, "R9");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0000, "R9");
      chk(mode_op == 12'h233, "R9", "mode_op", mode_op, 12'h233);
      issue(1, P_LMR,   2'd0, 13'h1045, 0, 1, 4'd8, 1, 4'b0000, "R9");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0000, "R9");
      chk(mode_op == 12'h045, "R9", "mode_op a12", mode_op, 12'h045);
      issue(1, P_REF,   2'd0, 13'h0000, 0, 1, 4'd6, 0, 4'b0000, "R10");
      issue(0, P_REF,   2'd0, 13'h0000, 0, 1, 4'd7, 0, 4'b0000, "R10");
      issue(0, P_ACT,   2'd2, 13'h0003, 0, 0, 4'd0, 0, 4'b0000, "R11");
      chk(self_ref == 1'b1, "R11", "self_ref entered", self_ref, 1);
      issue(1, P_ACT,   2'd2, 13'h0003, 0, 0, 4'd0, 0, 4'b0000, "R11");
      chk(self_ref == 1'b1, "R11", "self_ref held", self_ref, 1);
      issue(1, P_ACT,   2'd2, 13'h0003, 0, 1, 4'd1, 0, 4'b0100, "R11");
      chk(self_ref == 1'b0, "R11", "self_ref exit", self_ref, 0);
      issue(0, P_REF,   2'd0, 13'h0000, 0, 1, 4'd7, 1, 4'b0000, "R7");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0000, "R11");
      issue(1, P_NOP,   2'd0, 13'h0000, 0, 0, 4'd0, 0, 4'b0000, "R11");
      chk(self_ref == 1'b0, "R11", "self_ref after exit", self_ref, 0);

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule